// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

A purely combinational word shifter for an integer datapath. A data word is moved left or right by any distance from zero up to one less than the word width. The distance comes from a binary shift-amount input. A two-bit operation code selects how the vacated bit positions are filled: with zeros, with copies of the sign bit, or, when a build parameter enables it, with the bits that fall off the low end (rotation).

The network is a cascade of log2(W) multiplexer stages. The stage of weight 2^k either passes its input straight through or moves it by 2^k places, under control of bit k of the amount. Only right-moving stages exist. Left shifts mirror the word on the way in and on the way out, so that the same stages serve both directions. There are no registers, no flags and no handshake: the result follows the inputs in the same cycle.

Top module: `barrel_shift`

## Requirements
- R1: With an amount of 0 the result equals the input word for every operation code.
- R2: Operation code 2'b00 shifts left: result = data << amount, with zeros entering at bit 0.
- R3: Operation code 2'b01 shifts right logically: result = data >> amount, with zeros entering at the most significant bit.
- R4: Operation code 2'b10 shifts right arithmetically: the vacated high positions receive copies of data[W-1], so the sign bit of the result always equals the sign bit of the input.
- R5: With the rotate parameter set to 1, operation code 2'b11 rotates right: bit i of the result is data[(i + amount) mod W], and the number of set bits is preserved.
- R6: With the rotate parameter set to 0, operation code 2'b11 behaves exactly as the logical right shift of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | W | Word to be shifted |
| amt_i | input | log2(W) | Shift distance, 0 to W-1 |
| op_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| res_o | output | W | Shifted word |

## Verification
The checker tests, whenever the inputs are known, several properties: pass-through at amount 0, a zero at bit 0 after a nonzero left shift, a zero at the top bit after a nonzero logical right shift, sign preservation for the arithmetic shift, and preservation of the set-bit count for rotation. These properties cannot tell whether bits landed in the right positions. Only the bench's sweep shows that. It runs every amount under every operation code over a set of structured and pseudo-random words, and compares each result with values computed arithmetically. A second instance built without rotation provides the only evidence for the fallback behaviour of code 11.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_ROR = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shift_front.sv
module shift_front
  import shift_pkg::*;
#(
  parameter int W      = 32,
  parameter bit ROT_EN = 1'b1
) (
  input  logic [W-1:0] data_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] staged_o,
  output logic         fill_o,
  output logic         wrap_o,
  output logic         mirror_o
);
  logic [W-1:0] flipped;

  // Mirrored copy of the word, used when shifting left.
  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flipped[i] = data_i[W-1-i];
  end

  always_comb begin
    mirror_o = (op_i == OP_SLL);
    wrap_o   = ROT_EN && (op_i == OP_ROR);
    fill_o   = (op_i == OP_SRA) ? data_i[W-1] : 1'b0;
    staged_o = mirror_o ? flipped : data_i;
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0] x_i,
  input  logic         sel_i,
  input  logic         fill_i,
  input  logic         wrap_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i + DIST < W) begin : g_inner
      assign y_o[i] = sel_i ? x_i[i+DIST] : x_i[i];
    end else begin : g_edge
      // Top positions take either the fill bit or bits wrapped from the low end.
      assign y_o[i] = sel_i ? (wrap_i ? x_i[i+DIST-W] : fill_i) : x_i[i];
    end
  end
endmodule

// File: rtl/shift_back.sv
module shift_back #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic         mirror_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] flipped;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flipped[i] = x_i[W-1-i];
  end

  assign y_o = mirror_i ? flipped : x_i;
endmodule

// File: rtl/barrel_shift.sv
module barrel_shift #(
  parameter int W      = 32,
  parameter bit ROT_EN = 1'b1,
  localparam int SHW   = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SHW-1:0] amt_i,
  input  logic [1:0]     op_i,
  output logic [W-1:0]   res_o
);
  logic [W-1:0] chain [SHW+1];
  logic         fill;
  logic         wrap;
  logic         mirror;

  shift_front #(.W(W), .ROT_EN(ROT_EN)) u_front (
    .data_i   (data_i),
    .op_i     (op_i),
    .staged_o (chain[0]),
    .fill_o   (fill),
    .wrap_o   (wrap),
    .mirror_o (mirror)
  );

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    shift_stage #(.W(W), .DIST(1 << k)) u_stage (
      .x_i    (chain[k]),
      .sel_i  (amt_i[k]),
      .fill_i (fill),
      .wrap_i (wrap),
      .y_o    (chain[k+1])
    );
  end

  shift_back #(.W(W)) u_back (
    .x_i      (chain[SHW]),
    .mirror_i (mirror),
    .y_o      (res_o)
  );
endmodule

// File: rtl/barrel_shift_chk.sv
module barrel_shift_chk #(
  parameter int W      = 32,
  parameter bit ROT_EN = 1'b1,
  localparam int SHW   = $clog2(W)
) (
  input logic [W-1:0]   data_i,
  input logic [SHW-1:0] amt_i,
  input logic [1:0]     op_i,
  input logic [W-1:0]   res_o
);
  always_comb begin
    if (!$isunknown({data_i, amt_i, op_i, res_o})) begin
      if (amt_i == '0) begin
        a_r1_zero_passthru: assert (res_o == data_i)
          else $error("R1 pass-through broken");
      end
      if (op_i == 2'b00 && amt_i != '0) begin
        a_r2_low_zero: assert (res_o[0] == 1'b0)
          else $error("R2 low bit not zero");
      end
      if (op_i == 2'b01 && amt_i != '0) begin
        a_r3_top_zero: assert (res_o[W-1] == 1'b0)
          else $error("R3 top bit not zero");
      end
      if (op_i == 2'b10) begin
        a_r4_sign_kept: assert (res_o[W-1] == data_i[W-1])
          else $error("R4 sign lost");
      end
      if (ROT_EN && op_i == 2'b11) begin
        a_r5_ones_kept: assert ($countones(res_o) == $countones(data_i))
          else $error("R5 bit count changed");
      end
      if (!ROT_EN && op_i == 2'b11 && amt_i != '0) begin
        a_r6_top_zero: assert (res_o[W-1] == 1'b0)
          else $error("R6 top bit not zero");
      end
    end
  end
endmodule

bind barrel_shift barrel_shift_chk #(.W(W), .ROT_EN(ROT_EN)) u_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .op_i   (op_i),
  .res_o  (res_o)
);

// File: tb/sim_barrel_shift.sv
module sim_barrel_shift;
  localparam int W   = 32;
  localparam int SHW = 5;
  localparam int NPAT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]   data;
  logic [SHW-1:0] amt;
  logic [1:0]     op;
  logic [W-1:0]   res0;
  logic [W-1:0]   res1;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  barrel_shift #(.W(W), .ROT_EN(1'b1)) u0 (
    .data_i(data), .amt_i(amt), .op_i(op), .res_o(res0));

  barrel_shift #(.W(W), .ROT_EN(1'b0)) u1 (
    .data_i(data), .amt_i(amt), .op_i(op), .res_o(res1));

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d amt=%0d data=%h actual=%h expected=%h",
               req, op, amt, data, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_val(input logic [1:0] o,
      input logic [W-1:0] d, input int a);
    logic [2*W-1:0] dbl;
    dbl = {d, d} >> a;
    case (o)
      2'b00:   return d << a;
      2'b01:   return d >> a;
      2'b10:   return W'($signed(d) >>> a);
      default: return dbl[W-1:0];
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] o, input int a);
    if (a == 0) return "R1";
    case (o)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    logic [W-1:0] seed;
    logic [W-1:0] pat;
    data = '0; amt = '0; op = 2'b00;
    seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < NPAT; p++) begin
      case (p)
        0: pat = '0;
        1: pat = '1;
        2: pat = 32'h8000_0000;
        3: pat = 32'h0000_0001;
        4: pat = 32'hAAAA_5555;
        5: pat = 32'h7FFF_FFFF;
        6: pat = 32'h8000_0001;
        7: pat = 32'hF0F0_0F0F;
        default: begin
          seed = seed ^ (seed << 13);
          seed = seed ^ (seed >> 17);
          seed = seed ^ (seed << 5);
          pat = seed;
        end
      endcase
      for (int o = 0; o < 4; o++) begin
        for (int a = 0; a < W; a++) begin
          @(posedge clk);
          data = pat; op = 2'(o); amt = SHW'(a);
          @(negedge clk);
          check(req_of(2'(o), a), res0, expect_val(2'(o), pat, a));
          if (o == 3) begin
            // R6: without rotation, code 11 equals logical right shift
            check("R6", res1, pat >> a);
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule